// File: doc/BRIEF.md
# Serial Flash Host Interface Front End

This block is the host-facing serial port of a flash-style memory device. It runs on a fast system clock and oversamples the serial clock, chip select, pause, write-protect and two data pins. From these it rebuilds the bit stream the bus master sends: an instruction byte, an optional 24-bit address, and write data. It shifts back read data or the status byte on the two data lines through tri-state pad controls (`io_out`, `io_oe`). It works in a one-bit mode. For the dual-output and dual-I/O read instructions it works in a two-bit mode.

Decoded fields go to a simple command decoder as single-cycle pulses: the opcode, the address, and each full write byte. Read data comes back from that decoder on `rd_data`. The block pulses `rd_next` each time it takes a byte. The block owns an 8-bit status register. Bit 7 is the protect enable and bits 4:2 are the block-protect field; the array logic uses them together to decide which region is locked. The write-protect pin, together with bit 7, gates writes to this register.

The control state machine has the states LOCKED, DESEL, OPCODE, ADDR, WSTAT, WSDONE, WDATA, RDOUT, STOUT and IGNORE. The transitions are:

- LOCKED to DESEL: chip select is seen high. This is the only way out of LOCKED.
- Any state other than LOCKED to DESEL: chip select is seen high.
- DESEL to OPCODE: chip select is seen low.
- OPCODE, after the eighth instruction bit:
  - to STOUT for read-status (0x05),
  - to WSTAT for write-status (0x01),
  - to ADDR for the three reads (0x03, 0x3B, 0xBB) and program (0x02),
  - to IGNORE for any other code.
- ADDR, after the 24th address bit: to WDATA for program, otherwise to RDOUT.
- WSTAT, after the eighth data bit: to WSDONE.

Top module: `spi_flash_front`

## Requirements
- R1: After reset, no instruction is accepted and no field is handed off until chip select has been seen high and then low again. This holds even if chip select was already low during reset.
- R2: In one-bit mode, bits are sampled from `io_in[0]` on rising serial-clock edges. The first byte after selection is the opcode, MSB first. It is reported by a one-cycle `cmd_valid` pulse with `cmd_op`.
- R3: Opcodes 0x03, 0x3B, 0xBB and 0x02 take a 24-bit address, MSB first, reported by an `addr_valid` pulse. For 0xBB the address arrives two bits per rising edge, with `io_in[1]` carrying the more significant bit. For the other opcodes it arrives one bit per edge.
- R4: Read data changes on falling serial-clock edges, starting at the first falling edge after the last address bit. Each byte is taken from `rd_data` and announced by a `rd_next` pulse.
  - For 0x03, each byte goes out MSB first on `io_out[1]` with `io_oe`=2'b10.
  - For 0x3B and 0xBB, each byte goes out two bits per edge on `io_out[1:0]` (`io_out[1]` is the higher bit) with `io_oe`=2'b11.
- R5: While `cs_n` is high, `io_oe` is 2'b00. A rise of chip select at any point aborts the instruction, clears the bit count, and returns the next instruction to one-bit mode.
- R6: While `hold_n` is low with chip select low, `io_oe` is 2'b00 and serial-clock edges and data inputs are ignored. When `hold_n` returns high, the transfer resumes at the same bit.
- R7: Opcode 0x05 returns the status byte on `io_out[1]`, MSB first, repeated for every byte until deselection. This works whatever the state of the write-protect pin.
- R8: Opcode 0x01 loads the following data byte into the status register when chip select rises, and only if all 8 bits arrived. Only bits 7 and 4:2 are writable; all other bits read as 0. A partial byte is discarded.
- R9: A status write is blocked when `wp_n` is low and status bit 7 is 1.
- R10: The write-protect level that counts for a status write is the level present when chip select rises. A change of `wp_n` at the same instant as the rise of chip select is honoured.
- R11: Opcode 0x02 hands each complete 8-bit data byte after the address to the decoder with a `wdata_valid` pulse. A trailing partial byte is dropped.
- R12: An opcode other than the six listed is reported on `cmd_op`. All further clocks until deselection are ignored: no address pulse and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write-protect pin |
| io_in | input | 2 | Input levels of the two data pads |
| io_out | output | 2 | Output values of the two data pads |
| io_oe | output | 2 | Output enables of the two data pads |
| cmd_valid | output | 1 | One-cycle pulse: opcode received |
| cmd_op | output | 8 | Last opcode received |
| addr_valid | output | 1 | One-cycle pulse: address received |
| addr | output | 24 | Last address received |
| wdata_valid | output | 1 | One-cycle pulse: program byte received |
| wdata | output | 8 | Last program byte |
| rd_next | output | 1 | One-cycle pulse: read byte consumed |
| rd_data | input | 8 | Read byte supplied by the decoder |
| stat_reg | output | 8 | Current status register value |

## Verification
The sharpest collision is the status-write commit and a write-protect change landing in the same system cycle. The bench drops `wp_n` and raises `cs_n` in the same time step while the protect bit is set, and then raises `wp_n` together with `cs_n` while the pin was low. A read-status afterwards must show the old value in the first case and the new value in the second. A second overlap is a falling serial-clock edge against a pause: the bench lets each edge settle before it moves `hold_n`. It then confirms that bits clocked during the pause neither shift the written byte nor skip a read bit.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    typedef enum logic [3:0] {
        ST_LOCKED,
        ST_DESEL,
        ST_OPCODE,
        ST_ADDR,
        ST_WSTAT,
        ST_WSDONE,
        ST_WDATA,
        ST_RDOUT,
        ST_STOUT,
        ST_IGNORE
    } fe_state_t;

    localparam logic [7:0] OP_WRSR     = 8'h01;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_RDSR     = 8'h05;
    localparam logic [7:0] OP_READ_DO  = 8'h3B;
    localparam logic [7:0] OP_READ_DIO = 8'hBB;

    localparam logic [7:0] SR_WMASK    = 8'h9C;
    localparam int         SR_PROT_BIT = 7;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          W       = 6,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg import spi_flash_pkg::*; #(
    parameter int SR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  logic [SR_W-1:0] wr_byte,
    input  logic            wp_s,
    output logic [SR_W-1:0] stat_q
);

    logic blocked;

    always_comb begin
        blocked = !wp_s && stat_q[SR_PROT_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (wr_req && !blocked) begin
            stat_q <= wr_byte & SR_WMASK[SR_W-1:0];
        end
    end

    assert_wp_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wp_s && stat_q[SR_PROT_BIT]) |=> $stable(stat_q));

endmodule

// File: rtl/spi_out_shifter.sv
module spi_out_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic              step,
    input  logic              dual,
    input  logic [BYTE_W-1:0] src,
    output logic [1:0]        bits,
    output logic              active,
    output logic              take
);

    localparam int CW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            bits   <= '0;
            active <= 1'b0;
            take   <= 1'b0;
        end else begin
            take <= 1'b0;
            if (clear || !en) begin
                cnt    <= '0;
                bits   <= '0;
                active <= 1'b0;
            end else if (step) begin
                active <= 1'b1;
                if (cnt == '0) begin
                    take <= 1'b1;
                    if (dual) begin
                        bits <= src[BYTE_W-1 -: 2];
                        sh   <= {src[BYTE_W-3:0], 2'b00};
                        cnt  <= CW'(BYTE_W - 2);
                    end else begin
                        bits <= {src[BYTE_W-1], 1'b0};
                        sh   <= {src[BYTE_W-2:0], 1'b0};
                        cnt  <= CW'(BYTE_W - 1);
                    end
                end else begin
                    if (dual) begin
                        bits <= sh[BYTE_W-1 -: 2];
                        sh   <= {sh[BYTE_W-3:0], 2'b00};
                        cnt  <= cnt - CW'(2);
                    end else begin
                        bits <= {sh[BYTE_W-1], 1'b0};
                        sh   <= {sh[BYTE_W-2:0], 1'b0};
                        cnt  <= cnt - CW'(1);
                    end
                end
            end
        end
    end

    assert_clear_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!active && !take));

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm import spi_flash_pkg::*; #(
    parameter int OP_W   = 8,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_s,
    input  logic              hold_s,
    input  logic [1:0]        io_s,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              wdata_valid,
    output logic [OP_W-1:0]   wdata,
    output logic              sr_wr_req,
    output logic [OP_W-1:0]   sr_wr_byte,
    output logic              out_en,
    output logic              out_stat,
    output logic              out_dual,
    output logic              fall_live
);

    localparam int CNT_W = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LEN_OP = CNT_W'(OP_W);
    localparam logic [CNT_W-1:0] LEN_AD = CNT_W'(ADDR_W);

    fe_state_t         state, nxt;
    logic              sck_d;
    logic [CNT_W-1:0]  bit_cnt, in_w, field_len;
    logic [ADDR_W-1:0] sh, sh_nxt;
    logic [OP_W-1:0]   op_new;
    logic              dual_in, dual_out, is_prog_q;
    logic              live, rise, fall, taking, field_done;

    always_comb begin
        live       = !cs_s && hold_s;
        rise       = sck_s && !sck_d;
        fall       = !sck_s && sck_d;
        in_w       = (state == ST_ADDR && dual_in) ? CNT_W'(2) : CNT_W'(1);
        field_len  = (state == ST_ADDR) ? LEN_AD : LEN_OP;
        field_done = ((bit_cnt + in_w) == field_len);
        sh_nxt     = (in_w == CNT_W'(2)) ? {sh[ADDR_W-3:0], io_s}
                                         : {sh[ADDR_W-2:0], io_s[0]};
        op_new     = sh_nxt[OP_W-1:0];
        taking     = rise && live &&
                     (state == ST_OPCODE || state == ST_ADDR ||
                      state == ST_WSTAT  || state == ST_WDATA);
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (state == ST_LOCKED) begin
            if (cs_s) nxt = ST_DESEL;
        end else if (cs_s) begin
            nxt = ST_DESEL;
        end else begin
            unique case (state)
                ST_DESEL:  nxt = ST_OPCODE;
                ST_OPCODE: if (taking && field_done) begin
                    unique case (op_new)
                        OP_RDSR:  nxt = ST_STOUT;
                        OP_WRSR:  nxt = ST_WSTAT;
                        OP_READ, OP_READ_DO, OP_READ_DIO, OP_PROG:
                                  nxt = ST_ADDR;
                        default:  nxt = ST_IGNORE;
                    endcase
                end
                ST_ADDR:   if (taking && field_done)
                               nxt = is_prog_q ? ST_WDATA : ST_RDOUT;
                ST_WSTAT:  if (taking && field_done) nxt = ST_WSDONE;
                default:   nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= nxt;
    end

    // datapath and handoff outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d       <= 1'b0;
            bit_cnt     <= '0;
            sh          <= '0;
            dual_in     <= 1'b0;
            dual_out    <= 1'b0;
            is_prog_q   <= 1'b0;
            cmd_valid   <= 1'b0;
            cmd_op      <= '0;
            addr_valid  <= 1'b0;
            addr        <= '0;
            wdata_valid <= 1'b0;
            wdata       <= '0;
            sr_wr_byte  <= '0;
        end else begin
            sck_d       <= sck_s;
            cmd_valid   <= 1'b0;
            addr_valid  <= 1'b0;
            wdata_valid <= 1'b0;
            if (cs_s || state == ST_LOCKED) begin
                bit_cnt  <= '0;
                dual_in  <= 1'b0;
                dual_out <= 1'b0;
            end else if (taking) begin
                sh <= sh_nxt;
                if (field_done) begin
                    bit_cnt <= '0;
                    unique case (state)
                        ST_OPCODE: begin
                            cmd_valid <= 1'b1;
                            cmd_op    <= op_new;
                            is_prog_q <= (op_new == OP_PROG);
                            dual_in   <= (op_new == OP_READ_DIO);
                            dual_out  <= (op_new == OP_READ_DIO) ||
                                         (op_new == OP_READ_DO);
                        end
                        ST_ADDR: begin
                            addr_valid <= 1'b1;
                            addr       <= sh_nxt;
                        end
                        ST_WSTAT: sr_wr_byte <= op_new;
                        default: begin
                            wdata_valid <= 1'b1;
                            wdata       <= op_new;
                        end
                    endcase
                end else begin
                    bit_cnt <= bit_cnt + in_w;
                end
            end
        end
    end

    // outputs toward the shifter and status register
    always_comb begin
        sr_wr_req = (state == ST_WSDONE) && cs_s;
        out_en    = (state == ST_RDOUT) || (state == ST_STOUT);
        out_stat  = (state == ST_STOUT);
        out_dual  = (state == ST_RDOUT) && dual_out;
        fall_live = fall && live;
    end

    assert_locked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && !cs_s) |=> (state == ST_LOCKED && !cmd_valid));

    assert_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && state != ST_LOCKED) |=>
            (state == ST_DESEL && !dual_in && !dual_out && bit_cnt == '0));

    assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s && state != ST_DESEL && state != ST_LOCKED) |=>
            ($stable(bit_cnt) && $stable(state) && $stable(sh)));

    assert_ignore_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |=> (!addr_valid && !wdata_valid));

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front import spi_flash_pkg::*; #(
    parameter int SYNC_STAGES = 2,
    parameter int OP_W        = 8,
    parameter int ADDR_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic [1:0]        io_in,
    output logic [1:0]        io_out,
    output logic [1:0]        io_oe,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              wdata_valid,
    output logic [OP_W-1:0]   wdata,
    output logic              rd_next,
    input  logic [OP_W-1:0]   rd_data,
    output logic [OP_W-1:0]   stat_reg
);

    // pin order: sck, cs, hold, wp, io[1:0]; cs resets low so LOCKED needs a real high
    localparam int          PIN_W   = 6;
    localparam logic [PIN_W-1:0] PIN_RST = 6'b0_0_1_1_00;

    logic [PIN_W-1:0] pins_s;
    logic             sck_s, cs_s, hold_s, wp_s;
    logic [1:0]       io_s;
    logic             sr_wr_req, out_en, out_stat, out_dual, fall_live;
    logic [OP_W-1:0]  sr_wr_byte, out_src;
    logic [1:0]       sh_bits;
    logic             sh_active, sh_take;

    spi_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck, cs_n, hold_n, wp_n, io_in}),
        .q     (pins_s)
    );

    assign {sck_s, cs_s, hold_s, wp_s, io_s} = pins_s;

    spi_shift_fsm #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_s       (sck_s),
        .cs_s        (cs_s),
        .hold_s      (hold_s),
        .io_s        (io_s),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .addr_valid  (addr_valid),
        .addr        (addr),
        .wdata_valid (wdata_valid),
        .wdata       (wdata),
        .sr_wr_req   (sr_wr_req),
        .sr_wr_byte  (sr_wr_byte),
        .out_en      (out_en),
        .out_stat    (out_stat),
        .out_dual    (out_dual),
        .fall_live   (fall_live)
    );

    spi_status_reg #(.SR_W(OP_W)) u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (sr_wr_req),
        .wr_byte (sr_wr_byte),
        .wp_s    (wp_s),
        .stat_q  (stat_reg)
    );

    assign out_src = out_stat ? stat_reg : rd_data;

    spi_out_shifter #(.BYTE_W(OP_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cs_s),
        .en     (out_en),
        .step   (fall_live),
        .dual   (out_dual),
        .src    (out_src),
        .bits   (sh_bits),
        .active (sh_active),
        .take   (sh_take)
    );

    logic pad_live;

    always_comb begin
        pad_live = !cs_n && hold_n;
        rd_next  = sh_take && !out_stat;
        if (sh_active && pad_live) begin
            io_oe  = out_dual ? 2'b11 : 2'b10;
            io_out = sh_bits;
        end else begin
            io_oe  = 2'b00;
            io_out = 2'b00;
        end
    end

    assert_oe_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_n) |-> (io_oe == 2'b00));

    assert_rdnext_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_next |-> $past(fall_live));

endmodule

// File: tb/sim_spi_flash_front.sv
`timescale 1ns/1ps
module sim_spi_flash_front;

    logic        clk = 1'b0;
    logic        rst_n, sck, cs_n, hold_n, wp_n;
    logic [1:0]  io_in, io_out, io_oe;
    logic        cmd_valid, addr_valid, wdata_valid, rd_next;
    logic [7:0]  cmd_op, wdata, rd_data, stat_reg;
    logic [23:0] addr;

    int n_chk = 0, n_bad = 0;
    int n_cmd = 0, n_addr = 0, n_wd = 0, rd_idx = 0;
    logic [7:0]  last_op, wd_log [4];
    logic [23:0] last_addr;
    bit done = 0;

    always #5 clk = ~clk;

    spi_flash_front u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
        .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .addr_valid(addr_valid),
        .addr(addr), .wdata_valid(wdata_valid), .wdata(wdata),
        .rd_next(rd_next), .rd_data(rd_data), .stat_reg(stat_reg)
    );

    function automatic logic [7:0] rdv(input int i);
        return 8'h5A + 8'(i * 29);
    endfunction

    assign rd_data = rdv(rd_idx);

    always @(posedge clk) begin
        if (cmd_valid)   begin last_op <= cmd_op; n_cmd <= n_cmd + 1; end
        if (addr_valid)  begin last_addr <= addr; n_addr <= n_addr + 1; end
        if (wdata_valid) begin
            if (n_wd < 4) wd_log[n_wd] <= wdata;
            n_wd <= n_wd + 1;
        end
        if (rd_next) rd_idx <= rd_idx + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] din, output logic [1:0] dq, output logic [1:0] oe);
        io_in = din;
        repeat (6) @(posedge clk);
        #1; dq = io_out; oe = io_oe;
        sck = 1'b1;
        repeat (6) @(posedge clk);
        #1; sck = 1'b0;
    endtask

    task automatic settle(); repeat (6) @(posedge clk); #1; endtask
    task automatic cs_lo(); cs_n = 1'b0; settle(); endtask
    task automatic cs_hi(); cs_n = 1'b1; repeat (8) @(posedge clk); #1; endtask

    task automatic send_bits(input logic [7:0] b, input int hi, input int lo);
        logic [1:0] dq, oe;
        for (int i = hi; i >= lo; i--) xfer({1'b0, b[i]}, dq, oe);
    endtask

    task automatic send_dual(input logic [7:0] b);
        logic [1:0] dq, oe;
        for (int i = 3; i >= 0; i--) xfer({b[2*i+1], b[2*i]}, dq, oe);
    endtask

    task automatic read_single(output logic [7:0] v, output bit oe_ok);
        logic [1:0] dq, oe;
        oe_ok = 1;
        for (int i = 7; i >= 0; i--) begin
            xfer(2'b00, dq, oe);
            v[i] = dq[1];
            if (oe != 2'b10) oe_ok = 0;
        end
    endtask

    task automatic read_dual(output logic [7:0] v, output bit oe_ok);
        logic [1:0] dq, oe;
        oe_ok = 1;
        for (int i = 3; i >= 0; i--) begin
            xfer(2'b00, dq, oe);
            v[2*i+1] = dq[1];
            v[2*i]   = dq[0];
            if (oe != 2'b11) oe_ok = 0;
        end
    endtask

    task automatic rdsr(output logic [7:0] v);
        bit ok;
        cs_lo(); send_bits(8'h05, 7, 0); read_single(v, ok); cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] b);
        cs_lo(); send_bits(8'h01, 7, 0); send_bits(b, 7, 0); cs_hi();
    endtask

    task automatic t_powerup();
        logic [7:0] v;
        cs_n = 1'b0;
        send_bits(8'h01, 7, 0); send_bits(8'h9C, 7, 0);
        chk("R1 no opcode while locked", n_cmd, 0);
        cs_hi();
        chk("R1 status untouched by locked write", stat_reg, 8'h00);
        rdsr(v);
        chk("R1 first real command accepted", v, 8'h00);
        chk("R1 opcode count after arming", n_cmd, 1);
    endtask

    task automatic t_status_rw();
        logic [7:0] v1, v2;
        bit ok;
        wrsr(8'hFF);
        chk("R8 only writable bits kept", stat_reg, 8'h9C);
        cs_lo(); send_bits(8'h05, 7, 0);
        read_single(v1, ok); read_single(v2, ok); cs_hi();
        chk("R7 status byte 1", v1, 8'h9C);
        chk("R7 status repeats", v2, 8'h9C);
        chk("R7 single-bit enable", ok, 1);
        cs_lo(); send_bits(8'h01, 7, 0); send_bits(8'h00, 7, 3); cs_hi();
        chk("R8 partial byte discarded", stat_reg, 8'h9C);
        wrsr(8'h00);
        chk("R8 full byte commits", stat_reg, 8'h00);
    endtask

    task automatic t_wp();
        logic [7:0] v;
        wrsr(8'h8C);
        chk("R9 write with pin high", stat_reg, 8'h8C);
        wp_n = 1'b0;
        wrsr(8'h00);
        chk("R9 write blocked", stat_reg, 8'h8C);
        rdsr(v);
        chk("R7 status readable under write protect", v, 8'h8C);
        wp_n = 1'b1;
        wrsr(8'h04);
        chk("R9 write after pin released", stat_reg, 8'h04);
        wp_n = 1'b0;
        wrsr(8'h10);
        chk("R9 pin low but protect bit clear", stat_reg, 8'h10);
        wp_n = 1'b1;
    endtask

    task automatic t_same_cycle();
        wrsr(8'h80);
        cs_lo(); send_bits(8'h01, 7, 0); send_bits(8'h00, 7, 0);
        wp_n = 1'b0; cs_n = 1'b1;
        repeat (8) @(posedge clk); #1;
        chk("R10 wp drop with release blocks", stat_reg, 8'h80);
        cs_lo(); send_bits(8'h01, 7, 0); send_bits(8'h04, 7, 0);
        wp_n = 1'b1; cs_n = 1'b1;
        repeat (8) @(posedge clk); #1;
        chk("R10 wp rise with release allows", stat_reg, 8'h04);
    endtask

    task automatic t_read_single();
        logic [7:0] v;
        bit ok;
        int base, c0, a0;
        c0 = n_cmd; a0 = n_addr;
        cs_lo(); send_bits(8'h03, 7, 0);
        send_bits(8'h12, 7, 0); send_bits(8'h34, 7, 0); send_bits(8'h56, 7, 0);
        chk("R2 opcode handoff", last_op, 8'h03);
        chk("R2 one opcode pulse", n_cmd, c0 + 1);
        chk("R3 address handoff", last_addr, 24'h123456);
        chk("R3 one address pulse", n_addr, a0 + 1);
        base = rd_idx;
        for (int k = 0; k < 3; k++) begin
            read_single(v, ok);
            chk("R4 single read byte", v, rdv(base + k));
            chk("R4 single read enable", ok, 1);
        end
        cs_hi();
        chk("R4 bytes consumed", rd_idx, base + 3);
    endtask

    task automatic t_read_dual();
        logic [7:0] v;
        bit ok;
        int base;
        cs_lo(); send_bits(8'h3B, 7, 0);
        send_bits(8'h00, 7, 0); send_bits(8'hAB, 7, 0); send_bits(8'hCD, 7, 0);
        chk("R3 address for dual output", last_addr, 24'h00ABCD);
        base = rd_idx;
        for (int k = 0; k < 2; k++) begin
            read_dual(v, ok);
            chk("R4 dual output byte", v, rdv(base + k));
            chk("R4 dual output enable", ok, 1);
        end
        cs_hi();
    endtask

    task automatic t_read_dio();
        logic [7:0] v;
        bit ok;
        int base;
        cs_lo(); send_bits(8'hBB, 7, 0);
        send_dual(8'hFE); send_dual(8'hDC); send_dual(8'hBA);
        chk("R3 two-bit address", last_addr, 24'hFEDCBA);
        base = rd_idx;
        read_dual(v, ok);
        chk("R4 dual io byte", v, rdv(base));
        chk("R4 dual io enable", ok, 1);
        cs_hi();
    endtask

    task automatic t_program();
        int w0;
        w0 = n_wd;
        cs_lo(); send_bits(8'h02, 7, 0);
        send_bits(8'h00, 7, 0); send_bits(8'h01, 7, 0); send_bits(8'h02, 7, 0);
        chk("R3 program address", last_addr, 24'h000102);
        send_bits(8'hC3, 7, 0); send_bits(8'h7E, 7, 0); send_bits(8'hFF, 7, 4);
        cs_hi();
        chk("R11 two full bytes", n_wd, w0 + 2);
        chk("R11 first byte", wd_log[w0], 8'hC3);
        chk("R11 second byte", wd_log[w0 + 1], 8'h7E);
    endtask

    task automatic t_unknown();
        logic [1:0] dq, oe;
        int a0;
        bit quiet = 1;
        a0 = n_addr;
        cs_lo(); send_bits(8'hAB, 7, 0);
        for (int i = 0; i < 16; i++) begin
            xfer(2'(i), dq, oe);
            if (oe != 2'b00) quiet = 0;
        end
        cs_hi();
        chk("R12 opcode reported", last_op, 8'hAB);
        chk("R12 no output enable", quiet, 1);
        chk("R12 no address pulse", n_addr, a0);
        chk("R12 status untouched", stat_reg, 8'h04);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        bit ok;
        cs_lo(); send_bits(8'h03, 7, 0); send_bits(8'h00, 7, 0);
        send_bits(8'h00, 7, 0); send_bits(8'h00, 7, 0);
        read_single(v, ok); send_bits(8'h00, 7, 5);
        cs_n = 1'b1; @(posedge clk); #1;
        chk("R5 enable drops on deselect", io_oe, 2'b00);
        repeat (8) @(posedge clk); #1;
        cs_lo(); send_bits(8'hBB, 7, 0); send_dual(8'h55); cs_hi();
        cs_lo(); send_bits(8'h05, 7, 0); read_single(v, ok); cs_hi();
        chk("R5 single mode after abort", v, 8'h04);
        chk("R5 single enable after abort", ok, 1);
    endtask

    task automatic t_hold();
        logic [1:0] dq, oe;
        logic [7:0] v;
        cs_lo(); send_bits(8'h01, 7, 0); send_bits(8'h18, 7, 5);
        settle(); hold_n = 1'b0; settle();
        for (int i = 0; i < 3; i++) xfer(2'b01, dq, oe);
        settle(); hold_n = 1'b1; settle();
        send_bits(8'h18, 4, 0); cs_hi();
        chk("R6 write resumes at same bit", stat_reg, 8'h18);
        cs_lo(); send_bits(8'h05, 7, 0);
        for (int i = 7; i >= 5; i--) begin xfer(2'b00, dq, oe); v[i] = dq[1]; end
        settle(); hold_n = 1'b0; @(posedge clk); #1;
        chk("R6 enable off while paused", io_oe, 2'b00);
        settle();
        for (int i = 0; i < 3; i++) xfer(2'b00, dq, oe);
        settle(); hold_n = 1'b1; settle();
        chk("R6 enable back after pause", io_oe, 2'b10);
        for (int i = 4; i >= 0; i--) begin xfer(2'b00, dq, oe); v[i] = dq[1]; end
        cs_hi();
        chk("R6 read resumes at same bit", v, 8'h18);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        rst_n = 1'b0; sck = 1'b0; cs_n = 1'b0; hold_n = 1'b1; wp_n = 1'b1; io_in = 2'b00;
        repeat (5) @(posedge clk); #1;
        chk("R5 reset output enable", io_oe, 2'b00);
        chk("R8 reset status", stat_reg, 8'h00);
        rst_n = 1'b1;
        repeat (4) @(posedge clk); #1;
        t_powerup();
        t_status_rw();
        t_wp();
        t_same_cycle();
        t_read_single();
        t_read_dual();
        t_read_dio();
        t_program();
        t_unknown();
        t_abort();
        t_hold();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule